// File: doc/BRIEF.md
# Pseudo-Static Memory Host Controller

This block sits between a synchronous on-chip master and an external 16-bit pseudo-static memory that presents an asynchronous SRAM-style pin set. The master hands over one request at a time (read or write, a word address, write data and two byte enables). The controller then sequences the active-low select, write, output and byte-lane pins so that every access meets the memory's nanosecond limits. Each limit is turned into a whole number of clock cycles at elaboration, from a clock-period parameter given in picoseconds.

Each access walks through setup, strobe, hold and recovery phases. Reads sample the data bus on the final strobe cycle and return it with a single-cycle valid pulse; byte lanes that were not enabled come back as zero. Writes keep the output enable high for the whole access and drive the data bus only while the chip is selected. The bus is released before output enable can fall again. The memory array and its power-down control are outside this block.

Top module: `psram_host_ctl`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, the select, write, output-enable and both byte-lane pins are high, `mem_dq_oe` is low and `rd_valid` is low.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low and returns high exactly 21 cycles after the accepting edge at the default 4 ns clock, for reads and writes alike.
- R3: For every access the select pin is low for ceil(70 ns / period) consecutive cycles (18 at default), and `mem_addr` does not change while it is low.
- R4: In a write the write pin is low for ceil(45 ns / period) cycles (12 at default), starting one cycle after select falls. The lower-lane pin (bits 7:0) is low during that window exactly when `req_be[0]` was 1, and the upper-lane pin (bits 15:8) exactly when `req_be[1]` was 1. With `req_be` = 2'b00 no lane pin falls and memory is left unchanged.
- R5: During a write `mem_dq_oe` is high for every cycle the select pin is low and `mem_dq_out` carries the write data. `mem_dq_oe` is never high while output enable is low.
- R6: Output enable stays high for the whole of a write access; the write pin is never low while output enable is low.
- R7: In a read, output enable is low for ceil(60 ns / period) cycles (15 at default), starting one cycle after select falls. The byte-lane pins follow `req_be` in the same window and are high outside read or write strobes.
- R8: `rd_valid` is a one-cycle pulse 16 cycles after the accepting edge of a read (default timing). `rd_data` then holds the bus value from the last output-enable cycle, with bits 7:0 zeroed when `req_be[0]` was 0 and bits 15:8 zeroed when `req_be[1]` was 0.
- R9: Between accesses the select pin stays high for at least ceil(10 ns / period) cycles (3 at default). Output enable falls no sooner than that many cycles after the write pin rises.
- R10: The select pin is never held low for more than ceil(1000 ns / period) cycles (250 at default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | Controller idle, request may be taken |
| rd_data | output | 16 | Read data, masked by byte enables |
| rd_valid | output | 1 | One-cycle read completion pulse |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Data from memory |

## Verification
The bench numbers every rising edge and records the edge that accepts each request. A read's result is due at that edge plus 16, and `req_ready` is due back at that edge plus 21. The scoreboard stores the due edge with the expected word and compares it at the falling edge where `rd_valid` appears, so a pulse that comes early or late fails. The pin-level monitor measures run lengths of select, write and output enable, and the gaps between them, at falling edges. It checks each run against the cycle counts in the requirements when the pin rises again.

// File: rtl/psram_host_ctl.sv
module psram_host_ctl #(
  parameter int CLK_PS      = 4000,
  parameter int ADDR_W      = 20,
  parameter int T_SETUP_PS  = 0,
  parameter int T_CYCLE_PS  = 70000,
  parameter int T_WPULSE_PS = 45000,
  parameter int T_ACCESS_PS = 60000,
  parameter int T_GAP_PS    = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              req_ready,
  output logic [15:0]       rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int atleast1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  localparam int SETUP_C   = atleast1(cdiv(T_SETUP_PS, CLK_PS));
  localparam int WR_STB_C  = atleast1(cdiv(T_WPULSE_PS, CLK_PS));
  localparam int RD_STB_C  = atleast1(cdiv(T_ACCESS_PS, CLK_PS));
  localparam int CYC_C     = cdiv(T_CYCLE_PS, CLK_PS);
  localparam int WR_HOLD_C = atleast1(CYC_C - SETUP_C - WR_STB_C);
  localparam int RD_HOLD_C = atleast1(CYC_C - SETUP_C - RD_STB_C);
  localparam int REC_C     = atleast1(cdiv(T_GAP_PS, CLK_PS));
  localparam int MAX_A     = (WR_STB_C > RD_STB_C) ? WR_STB_C : RD_STB_C;
  localparam int MAX_B     = (WR_HOLD_C > RD_HOLD_C) ? WR_HOLD_C : RD_HOLD_C;
  localparam int MAX_C     = (SETUP_C > REC_C) ? SETUP_C : REC_C;
  localparam int MAX_AB    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_ALL   = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int CNT_W     = $clog2(MAX_ALL + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_RECOVER} phase_t;

  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic               wr_q;
  logic [1:0]         be_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [15:0]        wdata_q;

  wire        selected = (phase == S_SETUP) || (phase == S_STROBE) || (phase == S_HOLD);
  wire        strobing = (phase == S_STROBE);
  wire [15:0] lane_mask = {{8{be_q[1]}}, {8{be_q[0]}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= S_IDLE;
      cnt      <= '0;
      wr_q     <= 1'b0;
      be_q     <= 2'b00;
      addr_q   <= '0;
      wdata_q  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
      case (phase)
        S_IDLE: if (req_valid) begin
          wr_q    <= req_write;
          be_q    <= req_be;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          phase   <= S_SETUP;
          cnt     <= CNT_W'(SETUP_C - 1);
        end
        S_SETUP: if (cnt == '0) begin
          phase <= S_STROBE;
          cnt   <= wr_q ? CNT_W'(WR_STB_C - 1) : CNT_W'(RD_STB_C - 1);
        end
        S_STROBE: if (cnt == '0) begin
          if (!wr_q) begin
            rd_data  <= mem_dq_in & lane_mask;
            rd_valid <= 1'b1;
          end
          phase <= S_HOLD;
          cnt   <= wr_q ? CNT_W'(WR_HOLD_C - 1) : CNT_W'(RD_HOLD_C - 1);
        end
        S_HOLD: if (cnt == '0) begin
          phase <= S_RECOVER;
          cnt   <= CNT_W'(REC_C - 1);
        end
        S_RECOVER: if (cnt == '0) phase <= S_IDLE;
        default: phase <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (phase == S_IDLE);
  assign mem_addr   = addr_q;
  assign mem_ce_n   = !selected;
  assign mem_we_n   = !(strobing && wr_q);
  assign mem_oe_n   = !(strobing && !wr_q);
  assign mem_lb_n   = !(strobing && be_q[0]);
  assign mem_ub_n   = !(strobing && be_q[1]);
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = selected && wr_q;

endmodule

// File: rtl/psram_host_ctl_chk.sv
module psram_host_ctl_chk #(
  parameter int CLK_PS      = 4000,
  parameter int ADDR_W      = 20,
  parameter int T_GAP_PS    = 10000,
  parameter int T_MAXSEL_PS = 1000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic              mem_dq_oe
);

  localparam int GAP_C = ((T_GAP_PS + CLK_PS - 1) / CLK_PS < 1) ? 1 : (T_GAP_PS + CLK_PS - 1) / CLK_PS;
  localparam int CAP_C = (T_MAXSEL_PS + CLK_PS - 1) / CLK_PS;

  logic [31:0] sel_run;
  logic [31:0] gap_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_run <= '0;
      gap_run <= 32'(GAP_C);
    end else begin
      sel_run <= mem_ce_n ? '0 : sel_run + 1;
      gap_run <= !mem_ce_n ? '0 : ((gap_run < 32'd1024) ? gap_run + 1 : gap_run);
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe));

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R4
  lane_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_lb_n || !mem_ub_n) |-> (!mem_we_n || !mem_oe_n));

  // R5
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  // R6
  oe_high_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R8
  rdv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R9
  select_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (gap_run >= 32'(GAP_C)));

  // R10
  select_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_run <= 32'(CAP_C));

endmodule

bind psram_host_ctl psram_host_ctl_chk #(
  .CLK_PS(CLK_PS), .ADDR_W(ADDR_W), .T_GAP_PS(T_GAP_PS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n),
  .mem_ub_n(mem_ub_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/psram_host_ctl_test.sv
`timescale 1ns/1ps
module psram_host_ctl_test;

  localparam int RD_DUE = 16;
  localparam int RDY_DUE = 21;
  localparam int SEL_C = 18;
  localparam int WE_C = 12;
  localparam int OE_C = 15;
  localparam int GAP_C = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rd_valid;
  logic [15:0] rd_data;
  logic [19:0] mem_addr;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_out, mem_dq_in;

  always #2 clk = ~clk;

  psram_host_ctl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // device model
  logic [15:0] dev_mem [int unsigned];
  logic [15:0] dev_word;
  always_comb begin
    dev_word = dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : 16'h0000;
    mem_dq_in = (!mem_ce_n && !mem_oe_n) ? dev_word : 16'hA5A5;
  end
  always @(posedge clk) begin
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      logic [15:0] w;
      w = dev_word;
      if (!mem_lb_n) w[7:0] = mem_dq_out[7:0];
      if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
      dev_mem[int'(mem_addr)] = w;
    end
  end

  int checks = 0, fails = 0, cyc = 0;
  logic finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // scoreboard
  typedef struct { logic [15:0] data; int due; } item_t;
  item_t exp_q[$];
  logic [15:0] ref_mem [int unsigned];
  logic [1:0] cur_be = 2'b00;
  logic cur_wr = 1'b0;

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected rd_valid", 1, 0);
      else begin
        item_t it;
        it = exp_q.pop_front();
        check(rd_data == it.data, "R8 read data", rd_data, it.data);
        check(cyc == it.due, "R8 read due cycle", cyc, it.due);
      end
    end
  end

  // pin monitor
  int sel_run = 0, we_run = 0, oe_run = 0, gap_run = 100, since_we = 100;
  logic pce = 1'b1, pwe = 1'b1, poe = 1'b1, prv = 1'b0;
  logic [19:0] paddr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_we_n && !mem_oe_n) check(1'b0, "R6 write with OE low", 1, 0);
      if (mem_dq_oe && !mem_oe_n) check(1'b0, "R5 drive with OE low", 1, 0);
      if (prv && rd_valid) check(1'b0, "R8 pulse too long", 1, 0);
      if (!mem_ce_n && !pce && mem_addr != paddr) check(1'b0, "R3 address moved", mem_addr, paddr);
      if (!mem_ce_n && pce) check(gap_run >= GAP_C, "R9 select gap", gap_run, GAP_C);
      if (mem_ce_n && !pce) check(sel_run == SEL_C, "R3/R10 select length", sel_run, SEL_C);
      if (!mem_we_n && pwe) begin
        check(mem_lb_n == !cur_be[0] && mem_ub_n == !cur_be[1], "R4 lane strobes",
              {mem_ub_n, mem_lb_n}, {!cur_be[1], !cur_be[0]});
        check(mem_dq_oe && !mem_ce_n, "R5 data driven in write", mem_dq_oe, 1);
      end
      if (mem_we_n && !pwe) check(we_run == WE_C, "R4 write pulse length", we_run, WE_C);
      if (!mem_oe_n && poe) begin
        check(since_we >= GAP_C, "R9 OE after WE rise", since_we, GAP_C);
        check(mem_lb_n == !cur_be[0] && mem_ub_n == !cur_be[1], "R7 read lanes",
              {mem_ub_n, mem_lb_n}, {!cur_be[1], !cur_be[0]});
        check(!cur_wr, "R6 OE in write", cur_wr, 0);
      end
      if (mem_oe_n && !poe) check(oe_run == OE_C, "R7 OE length", oe_run, OE_C);
      sel_run  = mem_ce_n ? 0 : sel_run + 1;
      gap_run  = mem_ce_n ? gap_run + 1 : 0;
      we_run   = mem_we_n ? 0 : we_run + 1;
      oe_run   = mem_oe_n ? 0 : oe_run + 1;
      since_we = mem_we_n ? since_we + 1 : 0;
      pce = mem_ce_n; pwe = mem_we_n; poe = mem_oe_n; prv = rd_valid; paddr = mem_addr;
    end
  end

  task automatic issue(input bit wr, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    int acc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    cur_be = be; cur_wr = wr;
    @(posedge clk);
    @(negedge clk);
    acc = cyc;
    req_valid = 1'b0;
    check(!req_ready, "R2 busy after accept", req_ready, 0);
    if (wr) begin
      logic [15:0] w;
      w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
      if (be[0]) w[7:0] = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      ref_mem[int'(a)] = w;
    end else begin
      item_t it;
      it.data = (ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000) & {{8{be[1]}}, {8{be[0]}}};
      it.due = acc + RD_DUE;
      exp_q.push_back(it);
    end
    while (!req_ready) @(negedge clk);
    check(cyc == acc + RDY_DUE, "R2 ready return", cyc, acc + RDY_DUE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready && mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe && !rd_valid,
          "R1 reset pins", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 6'b111110);
    rst_n = 1'b1;
    issue(1, 20'h00010, 16'h1234, 2'b11);
    issue(0, 20'h00010, 16'h0000, 2'b11);
    issue(1, 20'h00010, 16'hABCD, 2'b01);            // R4 lower lane only
    issue(0, 20'h00010, 16'h0000, 2'b11);
    issue(1, 20'h00010, 16'h5E77, 2'b10);            // R4 upper lane only
    issue(0, 20'h00010, 16'h0000, 2'b11);
    issue(1, 20'h00010, 16'hFFFF, 2'b00);            // R4 no lanes, no change
    issue(0, 20'h00010, 16'h0000, 2'b11);
    issue(0, 20'h00010, 16'h0000, 2'b01);            // R8 upper zeroed
    issue(0, 20'h00010, 16'h0000, 2'b10);            // R8 lower zeroed
    issue(1, 20'hFFFFF, 16'hC0DE, 2'b11);
    issue(1, 20'h00000, 16'h0F0F, 2'b11);
    issue(0, 20'hFFFFF, 16'h0000, 2'b11);
    issue(0, 20'h00000, 16'h0000, 2'b11);
    issue(0, 20'h00033, 16'h0000, 2'b11);            // unwritten word
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R8 all reads returned", exp_q.size(), 0);
    check(req_ready && mem_ce_n && !mem_dq_oe, "R1 idle after traffic", req_ready, 1);
    wrap_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    wrap_up();
  end

endmodule